// File: doc/BRIEF.md
# Two-Step 64-Bit Minimum/Maximum Unit

This block holds a 64-bit value as two 32-bit registers: an accumulator for the upper word and a product register for the lower word. It clamps that value against a 64-bit bound in two single-cycle operations. The upper-word step compares the accumulator with a 32-bit operand as signed numbers. It replaces the accumulator when the bound wins, and it records the outcome in the N and Z flags. The lower-word step does not compare on its own. The flags left by the upper-word step decide whether it loads the operand into the product register, compares the two as unsigned values, or leaves the register alone. A sticky V flag records a replacement that happened in the equal-upper-word case.

The unit offers a minimum pair and a maximum pair. Running a minimum pair and then a maximum pair against a high and a low bound saturates a signed 64-bit value. Load operations fill either word, and a separate operation clears V. A repeat count can be armed in advance. The compare steps cannot be repeated, so any started operation clears that count and runs exactly once.

Top module: `minmax64_unit`

## Requirements
- R1: After reset, the accumulator, the product register, N, Z, V, done_o and the repeat count all read zero.
- R2: Op 0 writes the operand to the accumulator and op 1 writes it to the product register. Neither changes N, Z or V. Op 7 changes nothing at all.
- R3: Op 2 (upper minimum) compares the accumulator with the operand as signed 32-bit values and sets N=1,Z=0 when it is less, N=0,Z=1 when it is equal, and N=0,Z=0 when it is greater. The accumulator takes the operand only when it is greater. V is left unchanged.
- R4: Op 4 (upper maximum) sets N and Z exactly as R3 does. The accumulator takes the operand only when it is less.
- R5: Op 3 (lower minimum) with N=0,Z=0 on entry loads the operand into the product register unconditionally, and V is left unchanged.
- R6: Op 3 with N=0,Z=1 compares the product register and the operand as unsigned values. When the register is greater, it takes the operand and V is set to 1. Otherwise the register and V both hold.
- R7: Op 3 with N=1 on entry leaves the product register and V unchanged.
- R8: Op 5 (lower maximum) loads the operand when N=1,Z=0. With Z=1 it replaces the register and sets V only when the register is unsigned-less than the operand. With N=0,Z=0 it holds.
- R9: The lower-word ops leave the accumulator, N and Z unchanged. Only op 6 clears V, and nothing else ever lowers it.
- R10: Every op takes effect at the clock edge that samples start_i high. done_o is high for exactly the one cycle after that edge.
- R11: rpt_load_i loads rpt_count_i into the repeat count when start_i is low. A start clears the count to zero, even when rpt_load_i is high in the same cycle, and the op executes only once.
- R12: A load of {ACC,P}, followed by an upper and lower minimum against bound Hmax and then an upper and lower maximum against bound Hmin, leaves {ACC,P} equal to the signed 64-bit clamp of the value to [Hmin, Hmax].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Execute op_i in this cycle |
| op_i | input | 3 | Operation select (codes in R2 to R9) |
| operand_i | input | WORD_W | Memory operand |
| rpt_load_i | input | 1 | Arm the repeat count |
| rpt_count_i | input | RPT_W | Repeat count to arm |
| acc_o | output | WORD_W | Accumulator (upper word) |
| p_o | output | WORD_W | Product register (lower word) |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| v_o | output | 1 | Sticky overflow/replacement flag |
| done_o | output | 1 | One-cycle completion pulse |
| rpt_cnt_o | output | RPT_W | Pending repeat count |

## Verification
The bench targets the equal-upper-word case. Values such as 0x80000000 and 0xFFFFFFFF in the lower word catch a design that compares P as signed, because such a design would keep the wrong word. It also drives the N=1 and N=0,Z=0 entries. A design that swaps the load and hold conditions would corrupt P there, and one that clears V outside op 6 would lose the sticky record. Random saturation runs bias the upper words toward the bound, so that any error in either step shows up as a wrong 64-bit clamp. A start issued while a repeat count is pending must leave the count at zero and produce only one done pulse.

// File: rtl/minmax64_pkg.sv
// Package: operation codes shared by the unit, its checker and its bench.
package minmax64_pkg;
    typedef enum logic [2:0] {
        OP_LD_HI  = 3'd0,
        OP_LD_LO  = 3'd1,
        OP_MIN_HI = 3'd2,
        OP_MIN_LO = 3'd3,
        OP_MAX_HI = 3'd4,
        OP_MAX_LO = 3'd5,
        OP_CLR_V  = 3'd6,
        OP_NOP    = 3'd7
    } mm_op_e;
endpackage

// File: rtl/mm_hi_cmp.sv
// Module: mm_hi_cmp
// Signed compare of the upper word with the operand. Produces the N/Z
// outcome and the greater/less indications. Pure combinational logic.
// Assumes both inputs are two's-complement words.
module mm_hi_cmp #(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] acc_i,
    input  logic [WORD_W-1:0] opnd_i,
    output logic              n_o,
    output logic              z_o,
    output logic              gt_o,
    output logic              lt_o
);
    // Signed relation between accumulator and operand
    always_comb begin
        lt_o = $signed(acc_i) < $signed(opnd_i);
        z_o  = acc_i == opnd_i;
        gt_o = !lt_o && !z_o;
        n_o  = lt_o;
    end
endmodule

// File: rtl/mm_lo_sel.sv
// Module: mm_lo_sel
// Decides the lower-word action from the flags left by the upper step:
// load, unsigned compare, or hold. Pure combinational logic.
// Assumes N and Z describe the upper-word relation of the same pair.
module mm_lo_sel #(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] p_i,
    input  logic [WORD_W-1:0] opnd_i,
    input  logic              n_i,
    input  logic              z_i,
    input  logic              max_mode_i,
    output logic              take_o,
    output logic              set_v_o
);
    logic p_gt, p_lt, eq_case, force_case;

    // Unsigned relation of the lower words
    always_comb begin
        p_gt = p_i > opnd_i;
        p_lt = p_i < opnd_i;
    end

    // Flag-driven choice between forced load and conditional compare
    always_comb begin
        eq_case    = !n_i && z_i;
        force_case = max_mode_i ? (n_i && !z_i) : (!n_i && !z_i);
        set_v_o    = eq_case && (max_mode_i ? p_lt : p_gt);
        take_o     = force_case || set_v_o;
    end
endmodule

// File: rtl/minmax64_unit.sv
// Module: minmax64_unit
// Two-step 64-bit min/max on the register pair {ACC,P}. Each started op
// completes at the sampling edge. A pending repeat count is discarded by
// any start, because the compare steps are not repeatable.
// Assumes lower-word steps follow an upper-word step of the same kind.
module minmax64_unit
    import minmax64_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int RPT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [2:0]        op_i,
    input  logic [WORD_W-1:0] operand_i,
    input  logic              rpt_load_i,
    input  logic [RPT_W-1:0]  rpt_count_i,
    output logic [WORD_W-1:0] acc_o,
    output logic [WORD_W-1:0] p_o,
    output logic              n_o,
    output logic              z_o,
    output logic              v_o,
    output logic              done_o,
    output logic [RPT_W-1:0]  rpt_cnt_o
);
    localparam logic [WORD_W-1:0] WORD_ZERO = '0;

    mm_op_e            op;
    logic [WORD_W-1:0] acc_q, p_q;
    logic              n_q, z_q, v_q, done_q;
    logic [RPT_W-1:0]  rpt_q;
    logic              hi_n, hi_z, hi_gt, hi_lt;
    logic              lo_take, lo_set_v;

    assign op = mm_op_e'(op_i);

    mm_hi_cmp #(.WORD_W(WORD_W)) u_hi (
        .acc_i (acc_q),
        .opnd_i(operand_i),
        .n_o   (hi_n),
        .z_o   (hi_z),
        .gt_o  (hi_gt),
        .lt_o  (hi_lt)
    );

    mm_lo_sel #(.WORD_W(WORD_W)) u_lo (
        .p_i       (p_q),
        .opnd_i    (operand_i),
        .n_i       (n_q),
        .z_i       (z_q),
        .max_mode_i(op == OP_MAX_LO),
        .take_o    (lo_take),
        .set_v_o   (lo_set_v)
    );

    // Register pair and flags, updated by the selected op
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= WORD_ZERO;
            p_q   <= WORD_ZERO;
            n_q   <= 1'b0;
            z_q   <= 1'b0;
            v_q   <= 1'b0;
        end else if (start_i) begin
            case (op)
                OP_LD_HI: acc_q <= operand_i;
                OP_LD_LO: p_q   <= operand_i;
                OP_MIN_HI, OP_MAX_HI: begin
                    n_q <= hi_n;
                    z_q <= hi_z;
                    if ((op == OP_MIN_HI) ? hi_gt : hi_lt)
                        acc_q <= operand_i;
                end
                OP_MIN_LO, OP_MAX_LO: begin
                    if (lo_take)  p_q <= operand_i;
                    if (lo_set_v) v_q <= 1'b1;
                end
                OP_CLR_V: v_q <= 1'b0;
                default: ;
            endcase
        end
    end

    // Completion pulse and repeat count (any start discards the count)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            rpt_q  <= '0;
        end else begin
            done_q <= start_i;
            if (start_i)
                rpt_q <= '0;
            else if (rpt_load_i)
                rpt_q <= rpt_count_i;
        end
    end

    assign acc_o     = acc_q;
    assign p_o       = p_q;
    assign n_o       = n_q;
    assign z_o       = z_q;
    assign v_o       = v_q;
    assign done_o    = done_q;
    assign rpt_cnt_o = rpt_q;
endmodule

// File: rtl/minmax64_chk.sv
// Module: minmax64_chk
// Port-level temporal checks for minmax64_unit, attached by bind.
module minmax64_chk
    import minmax64_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int RPT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [2:0]        op_i,
    input logic [WORD_W-1:0] operand_i,
    input logic [WORD_W-1:0] acc_o,
    input logic [WORD_W-1:0] p_o,
    input logic              n_o,
    input logic              z_o,
    input logic              v_o,
    input logic              done_o,
    input logic [RPT_W-1:0]  rpt_cnt_o
);
    logic lo_op;
    assign lo_op = start_i && (op_i == OP_MIN_LO || op_i == OP_MAX_LO);

    assert_lo_force_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && op_i == OP_MIN_LO && !n_o && !z_o |=> p_o == $past(operand_i));

    assert_eq_replace_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && op_i == OP_MIN_LO && !n_o && z_o && p_o > operand_i
        |=> p_o == $past(operand_i) && v_o);

    assert_lo_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && op_i == OP_MIN_LO && n_o |=> $stable(p_o) && $stable(v_o));

    assert_lo_keeps_hi_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lo_op |=> $stable(acc_o) && $stable(n_o) && $stable(z_o));

    assert_v_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        v_o && !(start_i && op_i == OP_CLR_V) |=> v_o);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o);

    assert_rpt_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> rpt_cnt_o == '0);
endmodule

bind minmax64_unit minmax64_chk #(.WORD_W(WORD_W), .RPT_W(RPT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .operand_i(operand_i), .acc_o(acc_o), .p_o(p_o), .n_o(n_o),
    .z_o(z_o), .v_o(v_o), .done_o(done_o), .rpt_cnt_o(rpt_cnt_o)
);

// File: tb/minmax64_unit_tb.sv
// Directed bench for minmax64_unit: one task per scenario.
module minmax64_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W = 32;
    localparam int RW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [2:0]    op_i = 3'd7;
    logic [W-1:0]  operand_i = '0;
    logic          rpt_load_i = 1'b0;
    logic [RW-1:0] rpt_count_i = '0;
    logic [W-1:0]  acc_o, p_o;
    logic          n_o, z_o, v_o, done_o;
    logic [RW-1:0] rpt_cnt_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    minmax64_unit #(.WORD_W(W), .RPT_W(RW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .operand_i(operand_i), .rpt_load_i(rpt_load_i), .rpt_count_i(rpt_count_i),
        .acc_o(acc_o), .p_o(p_o), .n_o(n_o), .z_o(z_o), .v_o(v_o),
        .done_o(done_o), .rpt_cnt_o(rpt_cnt_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Issue one op; returns at the falling edge after the executing edge
    task automatic do_op(input logic [2:0] op, input logic [W-1:0] val);
        @(negedge clk);
        start_i = 1'b1; op_i = op; operand_i = val;
        @(negedge clk);
        start_i = 1'b0; op_i = 3'd7;
    endtask

    task automatic set_pair(input logic [W-1:0] hi, input logic [W-1:0] lo);
        do_op(3'd0, hi);
        do_op(3'd1, lo);
    endtask

    task automatic t_reset();
        check("R1 acc", acc_o, 0);
        check("R1 p", p_o, 0);
        check("R1 flags", {n_o, z_o, v_o, done_o}, 0);
        check("R1 rpt", rpt_cnt_o, 0);
    endtask

    task automatic t_loads();
        set_pair(32'h1234_5678, 32'h9ABC_DEF0);
        check("R2 acc load", acc_o, 64'h1234_5678);
        check("R2 p load", p_o, 64'h9ABC_DEF0);
        check("R2 flags kept", {n_o, z_o, v_o}, 0);
        do_op(3'd7, 32'hFFFF_FFFF);
        check("R2 nop", {acc_o, p_o}, 64'h1234_5678_9ABC_DEF0);
    endtask

    task automatic t_hi_steps();
        do_op(3'd0, 32'hFFFF_FFF0);          // -16
        do_op(3'd2, 32'd5);                   // less: keep
        check("R3 less acc", acc_o, 64'hFFFF_FFF0);
        check("R3 less flags", {n_o, z_o}, 2'b10);
        do_op(3'd2, 32'hFFFF_FFF0);
        check("R3 equal flags", {n_o, z_o}, 2'b01);
        do_op(3'd2, 32'h8000_0000);           // greater: take
        check("R3 greater acc", acc_o, 64'h8000_0000);
        check("R3 greater flags", {n_o, z_o}, 2'b00);
        do_op(3'd4, 32'h7FFF_FFFF);           // less: take max
        check("R4 max acc", acc_o, 64'h7FFF_FFFF);
        check("R4 max flags", {n_o, z_o}, 2'b10);
        do_op(3'd4, 32'd3);                   // greater: keep
        check("R4 max keep", acc_o, 64'h7FFF_FFFF);
        check("R3 v kept", v_o, 0);
    endtask

    task automatic t_lo_min();
        do_op(3'd6, 0);
        set_pair(32'd10, 32'h0000_0001);
        do_op(3'd2, 32'd3);                    // N=0,Z=0
        do_op(3'd3, 32'hFFFF_FFFF);
        check("R5 forced load", p_o, 64'hFFFF_FFFF);
        check("R5 v kept", v_o, 0);
        check("R9 acc kept", {acc_o, 30'd0, n_o, z_o}, {32'd3, 32'd0});
        set_pair(32'd3, 32'h8000_0000);
        do_op(3'd2, 32'd3);                    // Z=1
        do_op(3'd3, 32'h7FFF_FFFF);           // unsigned P greater
        check("R6 unsigned replace", p_o, 64'h7FFF_FFFF);
        check("R6 v set", v_o, 1);
        do_op(3'd6, 0);
        check("R9 clear v", v_o, 0);
        do_op(3'd3, 32'hFFFF_FFFF);           // P smaller: hold
        check("R6 hold", p_o, 64'h7FFF_FFFF);
        check("R6 v hold", v_o, 0);
        do_op(3'd2, 32'd9);                    // N=1
        do_op(3'd3, 32'd0);
        check("R7 hold", p_o, 64'h7FFF_FFFF);
        check("R9 flags kept", {n_o, z_o}, 2'b10);
    endtask

    task automatic t_lo_max();
        do_op(3'd6, 0);
        set_pair(32'd1, 32'hFFFF_FFFF);
        do_op(3'd4, 32'd2);                    // N=1
        do_op(3'd5, 32'd7);
        check("R8 forced load", p_o, 64'd7);
        do_op(3'd4, 32'd2);                    // Z=1 (acc now 2)
        do_op(3'd5, 32'h8000_0000);
        check("R8 eq replace", {p_o, 31'd0, v_o}, {32'h8000_0000, 32'd1});
        do_op(3'd5, 32'd1);
        check("R8 eq hold", p_o, 64'h8000_0000);
        do_op(3'd4, 32'd0);                    // N=0,Z=0
        do_op(3'd5, 32'hFFFF_FFFF);
        check("R8 greater hold", p_o, 64'h8000_0000);
        check("R9 v sticky", v_o, 1);
    endtask

    task automatic t_timing_rpt();
        @(negedge clk);
        rpt_load_i = 1'b1; rpt_count_i = 8'd5;
        @(negedge clk);
        rpt_load_i = 1'b0;
        check("R11 armed", rpt_cnt_o, 5);
        set_pair(32'd4, 32'd4);
        check("R11 start clears", rpt_cnt_o, 0);
        @(negedge clk);
        rpt_load_i = 1'b1; rpt_count_i = 8'd9;
        start_i = 1'b1; op_i = 3'd1; operand_i = 32'd77;
        @(negedge clk);
        start_i = 1'b0; rpt_load_i = 1'b0; op_i = 3'd7;
        check("R10 done pulse", done_o, 1);
        check("R10 one cycle result", p_o, 77);
        check("R11 start wins", rpt_cnt_o, 0);
        @(negedge clk);
        check("R10 single done", done_o, 0);
    endtask

    task automatic t_saturate(input int iters);
        for (int i = 0; i < iters; i++) begin
            logic signed [63:0] val, hmax, hmin, expv;
            logic [31:0] r;
            hmax = {$urandom, $urandom};
            hmin = {$urandom, $urandom};
            if (hmin > hmax) begin val = hmin; hmin = hmax; hmax = val; end
            val = {$urandom, $urandom};
            r = $urandom;
            case (r[1:0])
                2'd0: val[63:32] = hmax[63:32];
                2'd1: val[63:32] = hmin[63:32];
                default: ;
            endcase
            if (r[2]) val[31:0] = r[3] ? 32'hFFFF_FFFF : 32'h8000_0000;
            expv = val > hmax ? hmax : (val < hmin ? hmin : val);
            set_pair(val[63:32], val[31:0]);
            do_op(3'd2, hmax[63:32]);
            do_op(3'd3, hmax[31:0]);
            do_op(3'd4, hmin[63:32]);
            do_op(3'd5, hmin[31:0]);
            check("R12 saturate", {acc_o, p_o}, expv);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_loads();
        t_hi_steps();
        t_lo_min();
        t_lo_max();
        t_timing_rpt();
        t_saturate(300);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule